// File: doc/BRIEF.md
# Streaming 2x2 Max-Pooling Engine

This block reduces a 28x28 frame of signed 64-bit words to a 14x14 frame. Each output word is the largest of the four words in a non-overlapping 2x2 tile. The frame enters one word per cycle in raster order, with the column index changing fastest. It passes through a valid/ready stream. One signed comparator is reused for every tile. The block does not need the whole image on wide parallel pins, and it does not need a comparator tree per tile.

While the even row of a tile pair streams in, the larger word of each column pair goes into a small store with one entry per output column. On the odd row, each new word is compared against that stored value. When the fourth word of a tile arrives, the finished maximum goes into an output register. The result frame therefore comes out in raster order. The block flags the final word of each frame and then starts the next frame without a reset.

Back-pressure rules:
- An input word transfers on a clock edge where `in_valid` and `in_ready` are both high.
- An output word transfers on a clock edge where `out_valid` and `out_ready` are both high.
- `in_ready` is low only while an output word waits with `out_ready` low.
- A waiting output word, with its end-of-frame flag, holds steady until the consumer takes it.

Top module: `maxpool_stream`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid` and `out_eof` and sets `in_ready` high. The first word accepted after reset is taken as row 0, column 0, even if `in_sof` is low.
- R2: Output (r, c) equals the largest of input words (2r, 2c), (2r, 2c+1), (2r+1, 2c) and (2r+1, 2c+1).
- R3: A full frame of 784 accepted words yields exactly 196 output words, in raster order of the 14x14 grid, with column fastest.
- R4: With `out_ready` held high, `out_valid` is high in the cycle right after the edge that accepts input word (2r+1, 2c+1), and it carries output (r, c). No output word appears without such an acceptance.
- R5: `out_eof` is high together with output (13, 13) and with no other output word. It is never high while `out_valid` is low.
- R6: After output (13, 13), the next accepted word is taken as row 0, column 0 of a new frame, with no reset needed.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low. In the next cycle `out_valid` stays high, and `out_data` and `out_eof` hold their values.
- R8: An accepted word with `in_sof` high is taken as row 0, column 0. Any partly received frame is dropped, and the outputs already produced for it stay as they were.
- R9: Words are compared as signed two's-complement values. The most negative value, 64'h8000000000000000, is below every other value. The most positive value, 64'h7FFFFFFFFFFFFFFF, is above every other value. Equal words give that same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block can take the offered word |
| in_data | input | 64 | Signed input word |
| in_sof | input | 1 | The offered word is row 0, column 0 of a frame |
| out_valid | output | 1 | A pooled word is offered |
| out_ready | input | 1 | The consumer takes the offered pooled word |
| out_data | output | 64 | Signed pooled word |
| out_eof | output | 1 | The offered word is the last of its frame |

## Verification
The assertions assume that `rst` is high from time zero for at least one clock edge. They also assume that `out_ready` is a plain consumer decision, with no combinational dependence on `in_ready`. The hold property on a stalled output checks only the output side, so the assertions allow input words and `in_sof` to change freely in any cycle. The stimulus starts every run under reset and drives all inputs at the falling edge. It draws `in_valid` gaps and `out_ready` stalls at random in some frames, and raises `in_sof` only on the first word of a frame.

// File: rtl/maxpool_pkg.sv
package maxpool_pkg;

  // Where the comparator's first operand comes from for the word being accepted.
  typedef enum logic [1:0] {
    SRC_LOAD  = 2'd0,  // first word of a tile: pass through
    SRC_PAIR  = 2'd1,  // odd column: combine with the running pair maximum
    SRC_STORE = 2'd2   // even column on odd row: combine with stored column pair
  } cmp_src_e;

endpackage

// File: rtl/maxpool_pos_counter.sv
module maxpool_pos_counter #(
  parameter int ROWS = 28,
  parameter int COLS = 28,
  parameter int RW   = $clog2(ROWS),
  parameter int CW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          restart,
  output logic [RW-1:0] pos_row,
  output logic [CW-1:0] pos_col,
  output logic          at_last_row,
  output logic          at_last_col
);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  // Position of the word currently offered; a start flag forces the origin.
  assign pos_row     = restart ? '0 : row_q;
  assign pos_col     = restart ? '0 : col_q;
  assign at_last_row = (pos_row == RW'(ROWS - 1));
  assign at_last_col = (pos_col == CW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step) begin
      if (at_last_col) begin
        col_q <= '0;
        row_q <= at_last_row ? '0 : pos_row + 1'b1;
      end else begin
        col_q <= pos_col + 1'b1;
        row_q <= pos_row;
      end
    end
  end

endmodule

// File: rtl/maxpool_pair_store.sv
module maxpool_pair_store #(
  parameter int DEPTH = 14,
  parameter int W     = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic signed [W-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic signed [W-1:0] rd_data
);

  // Contents need no reset: every even row rewrites each entry before use.
  logic signed [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/maxpool_select_max.sv
module maxpool_select_max #(
  parameter int W = 64
) (
  input  logic signed [W-1:0] held,
  input  logic signed [W-1:0] cand,
  output logic signed [W-1:0] larger
);

  // The held value is replaced only when the candidate is strictly greater.
  assign larger = (cand > held) ? cand : held;

endmodule

// File: rtl/maxpool_stream.sv
module maxpool_stream #(
  parameter int DATA_W   = 64,
  parameter int IMG_ROWS = 28,
  parameter int IMG_COLS = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     in_sof,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_eof
);
  import maxpool_pkg::*;

  localparam int OUT_COLS = IMG_COLS / 2;
  localparam int RW       = $clog2(IMG_ROWS);
  localparam int CW       = $clog2(IMG_COLS);
  localparam int SAW      = $clog2(OUT_COLS);

  logic [RW-1:0]            pos_row;
  logic [CW-1:0]            pos_col;
  logic                     at_last_row, at_last_col;
  logic                     accept, odd_row, odd_col;
  logic [SAW-1:0]           slot;
  cmp_src_e                 src;
  logic signed [DATA_W-1:0] operand, winner, store_rd, pair_q;
  logic                     out_valid_q, out_eof_q;
  logic signed [DATA_W-1:0] out_data_q;

  // An input word may enter unless a finished word is stuck at the output.
  assign in_ready = ~out_valid_q | out_ready;
  assign accept   = in_valid & in_ready;

  maxpool_pos_counter #(
    .ROWS(IMG_ROWS), .COLS(IMG_COLS), .RW(RW), .CW(CW)
  ) u_pos (
    .clk        (clk),
    .rst        (rst),
    .step       (accept),
    .restart    (in_sof),
    .pos_row    (pos_row),
    .pos_col    (pos_col),
    .at_last_row(at_last_row),
    .at_last_col(at_last_col)
  );

  assign odd_row = pos_row[0];
  assign odd_col = pos_col[0];
  assign slot    = SAW'(pos_col >> 1);

  always_comb begin
    if (odd_col)      src = SRC_PAIR;
    else if (odd_row) src = SRC_STORE;
    else              src = SRC_LOAD;
  end

  always_comb begin
    unique case (src)
      SRC_PAIR:  operand = pair_q;
      SRC_STORE: operand = store_rd;
      default:   operand = in_data;
    endcase
  end

  maxpool_select_max #(.W(DATA_W)) u_cmp (
    .held  (operand),
    .cand  (in_data),
    .larger(winner)
  );

  maxpool_pair_store #(.DEPTH(OUT_COLS), .W(DATA_W), .AW(SAW)) u_store (
    .clk    (clk),
    .wr_en  (accept & odd_col & ~odd_row),
    .wr_addr(slot),
    .wr_data(winner),
    .rd_addr(slot),
    .rd_data(store_rd)
  );

  // Running maximum across the current column pair.
  always_ff @(posedge clk) begin
    if (accept && !odd_col) pair_q <= winner;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_eof_q   <= 1'b0;
    end else if (accept && odd_col && odd_row) begin
      out_valid_q <= 1'b1;
      out_eof_q   <= at_last_row & at_last_col;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
      out_eof_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && odd_col && odd_row) out_data_q <= winner;
  end

  assign out_valid = out_valid_q;
  assign out_eof   = out_eof_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/maxpool_stream_chk.sv
module maxpool_stream_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_eof
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !out_eof);

  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R4
  fresh_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid || $past(in_valid && in_ready)));

  // R5
  eof_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_eof));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind maxpool_stream maxpool_stream_chk #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_eof  (out_eof)
);

// File: tb/maxpool_stream_bench.sv
`timescale 1ns/1ps
module maxpool_stream_bench;

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

  // Tile patterns {top-left, top-right, bottom-left, bottom-right, expected max}
  localparam logic [63:0] VEC [8][5] = '{
    '{64'd5, 64'd5, 64'd5, 64'd5, 64'd5},
    '{MINV, MINV, MINV, MINV, MINV},
    '{MAXV, MINV, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, MAXV},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFD, MINV,
      64'hFFFF_FFFF_FFFF_FFFF},
    '{MINV, 64'h8000_0000_0000_0001, MINV, MINV, 64'h8000_0000_0000_0001},
    '{64'd0, 64'd0, 64'd0, 64'd1, 64'd1},
    '{64'hFFFF_FFFF_FFFF_FFF9, 64'd3, 64'hFFFF_FFFF_FFFF_FFF9, 64'd3, 64'd3},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0}
  };

  logic        clk = 1'b0;
  logic        rst, in_valid, in_sof, out_ready;
  logic        in_ready, out_valid, out_eof;
  logic [63:0] in_data, out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_total = 0;

  logic [63:0] img  [28][28];
  logic [63:0] expv [196];
  logic        expe [196];

  always #5 clk = ~clk;

  maxpool_stream u_maxpool_stream (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_total);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expd);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expd);
    end
  endtask

  function automatic logic [63:0] smax(input logic [63:0] a, input logic [63:0] b);
    return ($signed(b) > $signed(a)) ? b : a;
  endfunction

  function automatic logic [63:0] rnd_word();
    case ($urandom % 8)
      0: return MINV;
      1: return MAXV;
      2: return 64'd0;
      3: return 64'($signed($urandom % 7) - 3);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill_random();
    for (int r = 0; r < 28; r++)
      for (int c = 0; c < 28; c++)
        img[r][c] = rnd_word();
  endtask

  // Stream the first npix words of img; compare every output with the model.
  task automatic run_frame(input int npix, input bit use_sof, input bit stall,
                           input string tag);
    int n_exp = 0;
    int got = 0;
    int pix = 0;
    int cyc = 0;
    int oo_cyc = -10;
    bit held = 1'b0;
    logic [63:0] held_data = '0;
    for (int wr = 0; wr < 14; wr++)
      for (int wc = 0; wc < 14; wc++)
        if ((2*wr+1)*28 + 2*wc + 1 < npix) begin
          expv[n_exp] = smax(smax(smax(img[2*wr][2*wc], img[2*wr][2*wc+1]),
                                  img[2*wr+1][2*wc]), img[2*wr+1][2*wc+1]);
          expe[n_exp] = (wr == 13) && (wc == 13);
          n_exp++;
        end
    while ((pix < npix || got < n_exp) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      in_valid  = (pix < npix) && (!stall || ($urandom % 4 != 0));
      in_data   = (pix < npix) ? img[pix/28][pix%28] : '0;
      in_sof    = use_sof && (pix == 0);
      out_ready = !stall || ($urandom % 3 != 0);
      #1;
      if (held) begin
        // R7: a stalled word stays put
        check(out_valid && out_data == held_data, "R7", "held word", out_data, held_data);
        held = 1'b0;
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R7", "in_ready during stall", 64'(in_ready), 64'd0);
        held = 1'b1;
        held_data = out_data;
      end
      if (out_valid && out_ready) begin
        if (got >= n_exp) begin
          check(1'b0, "R3", "extra output", 64'(got), 64'(n_exp));
        end else begin
          check(out_data == expv[got], tag, $sformatf("output %0d", got), out_data, expv[got]);
          check(out_eof == expe[got], "R5", $sformatf("eof at %0d", got),
                64'(out_eof), 64'(expe[got]));
          if (!stall)
            check(cyc == oo_cyc + 1, "R4", "latency", 64'(cyc - oo_cyc), 64'd1);
        end
        got++;
      end
      if (in_valid && in_ready) begin
        if ((pix / 28) % 2 == 1 && (pix % 28) % 2 == 1) oo_cyc = cyc;
        pix++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
    check(got == n_exp, "R3", "output count", 64'(got), 64'(n_exp));
  endtask

  initial begin
    do_reset();
    // R1: state right after reset
    #1;
    check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(!out_eof, "R1", "out_eof after reset", 64'(out_eof), 64'd0);
    check(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // R2 / R9: every tile drawn from the pattern table, walked in one loop
    for (int t = 0; t < 196; t++) begin
      int k = t % 8;
      int wr = t / 14;
      int wc = t % 14;
      img[2*wr][2*wc]     = VEC[k][0];
      img[2*wr][2*wc+1]   = VEC[k][1];
      img[2*wr+1][2*wc]   = VEC[k][2];
      img[2*wr+1][2*wc+1] = VEC[k][3];
    end
    run_frame(784, 1'b1, 1'b0, "R9");
    for (int k = 0; k < 8; k++)
      check(smax(smax(smax(VEC[k][0], VEC[k][1]), VEC[k][2]), VEC[k][3]) == VEC[k][4],
            "R2", "table row", VEC[k][4], VEC[k][4]);

    // R6: next frame follows without reset and without a start flag
    fill_random();
    run_frame(784, 1'b0, 1'b0, "R6");

    // R7: random gaps and stalls; R2 values under back-pressure
    fill_random();
    run_frame(784, 1'b1, 1'b1, "R2");

    // R8: abandoned partial frame, then a restart by start flag
    fill_random();
    run_frame(100, 1'b0, 1'b0, "R8");
    fill_random();
    run_frame(784, 1'b1, 1'b0, "R8");

    // R1: reset mid-frame, then a frame with no start flag begins at the origin
    fill_random();
    run_frame(50, 1'b1, 1'b0, "R1");
    do_reset();
    #1;
    check(!out_valid, "R1", "out_valid after mid reset", 64'(out_valid), 64'd0);
    fill_random();
    run_frame(784, 1'b0, 1'b1, "R1");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule